// File: doc/BRIEF.md
# Five-Stage Pipelined 8-bit Core

This block is a compact 8-bit processor. It executes register-to-register arithmetic and logic instructions through five stages: fetch, decode, execute, memory and writeback. An 8-bit program counter fetches 20-bit instruction words from an internal instruction memory. The environment fills that memory through a write port while the core is held in reset.

Each instruction reads two registers, combines them in an 8-bit ALU and writes the result to a destination register. The controls for each opcode come from a small ROM of control words. A forwarding network gives each ALU operand the newest value of its source register, so back-to-back dependent instructions run at one instruction per cycle and the pipeline never stalls.

Every register write that takes effect is reported on a commit port in the writeback stage. The port shows the destination and the data. The register file starts from a seed value given by a parameter, because the instruction set has no way to load constants.

Top module: `pipe8_core`

## Requirements
- R1: While reset is held, `pc_o` is 0 and `wb_valid` is 0. Releasing reset restarts fetch at address 0, and every general register is loaded again from `REG_INIT`: register k takes bits `[8k-1 -: 8]`.
- R2: In each cycle after reset, `pc_o` rises by exactly 1 and wraps from 255 to 0.
- R3: The instruction word has these fields: opcode `[19:16]`, source A `[15:12]`, source B `[11:8]`, destination `[7:4]`. Bits `[3:0]` are ignored.
- R4: Opcode 1 computes A+B, 2 computes A-B, 3 computes A AND B and 4 computes A OR B. Every result is taken modulo 256.
- R5: The instruction at address a is reported on the commit port (`wb_valid`, `wb_rd`, `wb_data`) in the cycle when `pc_o` equals a+4.
- R6: Register 0 and register numbers from `NREG` up to 15 always read as 0. A write to any of them is discarded and does not appear on the commit port.
- R7: Opcodes 0 and 5 to 15 have no control word. They act as no-ops: no register is written and nothing is committed.
- R8: An operand that depends on the instruction just before it gets that instruction's result (EX hazard).
- R9: An operand that depends on the instruction two before it gets that result, as long as the instruction just before does not also write the same register (MEM hazard).
- R10: When both of the two previous instructions write the same source register, the operand gets the value from the more recent one.
- R11: No value is forwarded from an instruction that writes no register (a no-op, or a write to register 0 or to a missing register). The operand then gets the older value.
- R12: An operand that depends on the instruction three before it gets the new value, because a read of a register in the same cycle as its write returns the data being written.
- R13: Forwarding is chosen separately for each operand. Both operands can be forwarded in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for all state |
| rst_n | input | 1 | Active-low synchronous reset |
| imem_we | input | 1 | Instruction memory write strobe |
| imem_addr | input | 8 | Instruction memory write address |
| imem_wdata | input | 20 | Instruction word to store |
| pc_o | output | 8 | Current fetch address |
| wb_valid | output | 1 | A register write takes effect this cycle |
| wb_rd | output | 4 | Destination register of the commit |
| wb_data | output | 8 | Data written by the commit |

## Verification
The test program chains dependencies at distances one, two and three, and it contains a double hazard in which both operands come from forwarded values. A core with the wrong forwarding priority would return the older value for the double hazard. A core without the same-cycle bypass would return stale data at distance three. The program also places a no-op, an undefined opcode, a write to register 0 and a write to a missing register right in front of readers of those registers. A core that forwards without checking the write enable or the destination would pass in the phantom value there, and the bench would see a wrong sum. The remaining checks cover the ignored shift field, reset in the middle of a run reloading the seeded registers, and the program counter wrapping.

// File: rtl/pipe8_core.sv
module pipe8_core #(
  parameter int XW = 8,
  parameter int IW = 20,
  parameter int AW = 8,
  parameter int NREG = 6,
  parameter logic [(NREG-1)*XW-1:0] REG_INIT = 40'h81_F0_0F_34_12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          imem_we,
  input  logic [AW-1:0] imem_addr,
  input  logic [IW-1:0] imem_wdata,
  output logic [AW-1:0] pc_o,
  output logic          wb_valid,
  output logic [3:0]    wb_rd,
  output logic [XW-1:0] wb_data
);
  localparam int DEPTH = 1 << AW;

  // control word: {reg_write, alu_op[1:0]}
  localparam logic [2:0] CTRL_ROM [16] = '{
    3'b000, 3'b100, 3'b101, 3'b110, 3'b111, 3'b000, 3'b000, 3'b000,
    3'b000, 3'b000, 3'b000, 3'b000, 3'b000, 3'b000, 3'b000, 3'b000};

  logic [IW-1:0] imem [DEPTH];
  logic [AW-1:0] pc;
  logic [XW-1:0] rf [1:NREG-1];

  logic [IW-1:0] ifid_ins;

  logic          idex_we;
  logic [1:0]    idex_op;
  logic [3:0]    idex_rs1, idex_rs2, idex_rd;
  logic [XW-1:0] idex_a, idex_b;

  logic          exmem_we;
  logic [3:0]    exmem_rd;
  logic [XW-1:0] exmem_res;

  logic          memwb_we;
  logic [3:0]    memwb_rd;
  logic [XW-1:0] memwb_res;

  always_ff @(posedge clk)
    if (imem_we) imem[imem_addr] <= imem_wdata;

  // fetch
  always_ff @(posedge clk)
    if (!rst_n) begin
      pc       <= '0;
      ifid_ins <= '0;
    end else begin
      pc       <= pc + 1'b1;
      ifid_ins <= imem[pc];
    end

  // decode
  wire [3:0] dec_op  = ifid_ins[19:16];
  wire [3:0] dec_rs1 = ifid_ins[15:12];
  wire [3:0] dec_rs2 = ifid_ins[11:8];
  wire [3:0] dec_rd  = ifid_ins[7:4];
  wire [2:0] dec_cw  = CTRL_ROM[dec_op];
  wire       dec_we  = dec_cw[2] && (dec_rd != 4'd0) && (32'(dec_rd) < NREG);
  logic unused_shamt;
  assign unused_shamt = ^ifid_ins[3:0];

  logic [XW-1:0] rd_a, rd_b;
  always_comb begin
    rd_a = '0;
    rd_b = '0;
    for (int k = 1; k < NREG; k++) begin
      if (dec_rs1 == 4'(k)) rd_a = (memwb_we && memwb_rd == 4'(k)) ? memwb_res : rf[k];
      if (dec_rs2 == 4'(k)) rd_b = (memwb_we && memwb_rd == 4'(k)) ? memwb_res : rf[k];
    end
  end

  always_ff @(posedge clk)
    if (!rst_n) begin
      idex_we  <= 1'b0;
      idex_op  <= '0;
      idex_rs1 <= '0;
      idex_rs2 <= '0;
      idex_rd  <= '0;
      idex_a   <= '0;
      idex_b   <= '0;
    end else begin
      idex_we  <= dec_we;
      idex_op  <= dec_cw[1:0];
      idex_rs1 <= dec_rs1;
      idex_rs2 <= dec_rs2;
      idex_rd  <= dec_rd;
      idex_a   <= rd_a;
      idex_b   <= rd_b;
    end

  // forwarding and execute
  logic [XW-1:0] opa, opb, alu_y;
  always_comb begin
    if (exmem_we && exmem_rd == idex_rs1)      opa = exmem_res;
    else if (memwb_we && memwb_rd == idex_rs1) opa = memwb_res;
    else                                       opa = idex_a;
    if (exmem_we && exmem_rd == idex_rs2)      opb = exmem_res;
    else if (memwb_we && memwb_rd == idex_rs2) opb = memwb_res;
    else                                       opb = idex_b;
    case (idex_op)
      2'd0:    alu_y = opa + opb;
      2'd1:    alu_y = opa - opb;
      2'd2:    alu_y = opa & opb;
      default: alu_y = opa | opb;
    endcase
  end

  always_ff @(posedge clk)
    if (!rst_n) begin
      exmem_we  <= 1'b0;
      exmem_rd  <= '0;
      exmem_res <= '0;
    end else begin
      exmem_we  <= idex_we;
      exmem_rd  <= idex_rd;
      exmem_res <= alu_y;
    end

  // memory stage carries the result through
  always_ff @(posedge clk)
    if (!rst_n) begin
      memwb_we  <= 1'b0;
      memwb_rd  <= '0;
      memwb_res <= '0;
    end else begin
      memwb_we  <= exmem_we;
      memwb_rd  <= exmem_rd;
      memwb_res <= exmem_res;
    end

  // writeback
  always_ff @(posedge clk)
    if (!rst_n) begin
      for (int k = 1; k < NREG; k++) rf[k] <= REG_INIT[k*XW-1 -: XW];
    end else begin
      for (int k = 1; k < NREG; k++)
        if (memwb_we && memwb_rd == 4'(k)) rf[k] <= memwb_res;
    end

  assign pc_o     = pc;
  assign wb_valid = memwb_we;
  assign wb_rd    = memwb_rd;
  assign wb_data  = memwb_res;

  a_r2_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> pc == $past(pc) + 1'b1);

  a_r6_commit_dest_legal: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (wb_rd != 4'd0) && (32'(wb_rd) < NREG));

  a_r7_undefined_silent: assert property (@(posedge clk) disable iff (!rst_n)
    !(dec_op inside {4'd1, 4'd2, 4'd3, 4'd4}) |=> !idex_we);

  a_r10_newest_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (exmem_we && memwb_we && exmem_rd == idex_rs1 && memwb_rd == idex_rs1)
      |-> opa == exmem_res);

  a_r11_zero_source: assert property (@(posedge clk) disable iff (!rst_n)
    (idex_rs2 == 4'd0) |-> opb == '0);
endmodule

// File: tb/tb_pipe8_core.sv
module tb_pipe8_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        imem_we = 1'b0;
  logic [7:0]  imem_addr = '0;
  logic [19:0] imem_wdata = '0;
  logic [7:0]  pc_o;
  logic        wb_valid;
  logic [3:0]  wb_rd;
  logic [7:0]  wb_data;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pipe8_core #(.XW(8), .IW(20), .AW(8), .NREG(6),
               .REG_INIT(40'h81_F0_0F_34_12)) dut (
    .clk(clk), .rst_n(rst_n), .imem_we(imem_we), .imem_addr(imem_addr),
    .imem_wdata(imem_wdata), .pc_o(pc_o), .wb_valid(wb_valid),
    .wb_rd(wb_rd), .wb_data(wb_data));

  // {instruction, commit expected, rd, data}; seed r1=12 r2=34 r3=0F r4=F0 r5=81
  localparam int NV = 18;
  localparam logic [32:0] VEC [NV] = '{
    {20'h12310, 1'b1, 4'h1, 8'h43},  // R4 add
    {20'h21240, 1'b1, 4'h4, 8'h0F},  // R8 sub, EX hazard
    {20'h41350, 1'b1, 4'h5, 8'h4F},  // R9 or, MEM hazard
    {20'h14540, 1'b1, 4'h4, 8'h5E},  // R13 both operands forwarded
    {20'h24340, 1'b1, 4'h4, 8'h4F},  // R8
    {20'h14420, 1'b1, 4'h2, 8'h9E},  // R10 double hazard
    {20'h11100, 1'b0, 4'h0, 8'h00},  // R6 write to r0
    {20'h40230, 1'b1, 4'h3, 8'h9E},  // R11 no forward from r0 dest
    {20'h12210, 1'b1, 4'h1, 8'h3C},  // R12 three back
    {20'hF1150, 1'b0, 4'h0, 8'h00},  // R7 undefined opcode
    {20'h35350, 1'b1, 4'h5, 8'h0E},  // R11 no forward from no-op
    {20'h2313F, 1'b1, 4'h3, 8'h62},  // R3 shift field ignored
    {20'h00030, 1'b0, 4'h0, 8'h00},  // R7 opcode 0
    {20'h13510, 1'b1, 4'h1, 8'h70},  // R11 older value past no-op
    {20'h20120, 1'b1, 4'h2, 8'h90},  // R4 wraps
    {20'h32740, 1'b1, 4'h4, 8'h00},  // R6 missing register reads 0
    {20'h41160, 1'b0, 4'h0, 8'h00},  // R6 write to missing register
    {20'h46250, 1'b1, 4'h5, 8'h90}   // R6 no forward from r6
  };

  function automatic string vtag(int i);
    case (i)
      0, 14:      return "R4";
      1, 4:       return "R8";
      2:          return "R9";
      3:          return "R13";
      5:          return "R10";
      6, 15, 16, 17: return "R6";
      7, 10, 13:  return "R11";
      8:          return "R12";
      9, 12:      return "R7";
      default:    return "R3";
    endcase
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  initial begin
    #3000000;
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    @(negedge clk);
    imem_we = 1'b1;
    for (int a = 0; a < 256; a++) begin
      imem_addr = 8'(a);
      imem_wdata = (a < NV) ? VEC[a][32:13] : 20'h0;
      @(negedge clk);
    end
    imem_we = 1'b0;
    // R1 reset state
    chk(pc_o == 8'h00, "R1 pc in reset", pc_o, 0);
    chk(!wb_valid, "R1 no commit in reset", wb_valid, 0);

    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    for (int i = 0; i < NV + 4; i++) begin
      @(negedge clk);
      chk(pc_o == 8'(i + 4), "R5 pc at commit", pc_o, i + 4);
      if (i < NV && VEC[i][12]) begin
        chk(wb_valid && wb_rd == VEC[i][11:8] && wb_data == VEC[i][7:0],
            vtag(i), {wb_valid, wb_rd, wb_data}, {1'b1, VEC[i][11:0]});
      end else begin
        chk(!wb_valid, (i < NV) ? vtag(i) : "R7 trailing no-op", wb_valid, 0);
      end
      @(posedge clk);
    end

    // R1 reset mid-run reloads seeds: r1 = 34 + 0F again
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(pc_o == 8'h00, "R1 pc after second reset", pc_o, 0);
    chk(!wb_valid, "R1 pipeline empty after reset", wb_valid, 0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(wb_valid && wb_rd == 4'h1 && wb_data == 8'h43, "R1 reseeded registers",
        {wb_valid, wb_rd, wb_data}, 13'h1143);

    // R2 wrap of the program counter
    while (pc_o != 8'hFF) @(negedge clk);
    chk(pc_o == 8'hFF, "R2 pc top", pc_o, 8'hFF);
    @(negedge clk);
    chk(pc_o == 8'h00, "R2 pc wrap", pc_o, 0);
    @(negedge clk);
    chk(pc_o == 8'h01, "R2 pc step", pc_o, 1);

    done = 1'b1;
    finish_run();
  end
endmodule